// File: doc/BRIEF.md
# Outbound MMIO Window Decoder with Isolation-Group Lookup

This block sits on the outbound path from the CPU to a PCIe link. For each CPU memory-mapped address it decides whether one of its programmed windows claims the address. If one does, the block returns the PCIe address to be issued and the isolation group number that owns the access. Later stages use that group number to drop or poison traffic for a group that is frozen.

There are two kinds of window. The first is a single remapping window of at most 4 GB. It replaces the address bits above its size with a programmed value, so it can produce 32-bit bus addresses. It is split into 256 equal segments, and a 256-entry table gives the group of each segment. The second kind is a set of sixteen pass-through windows of at least 256 MB. Each of these is either unsegmented, with one group for the whole window, or segmented, where the 8-bit segment index is the group number itself. Windows may overlap, and a fixed priority decides which one applies. All state is loaded through a single write port.

A lookup is presented with `req_valid` and answered one clock later on the `rsp_*` outputs.

Top module: `mmio_win_decoder`

## Requirements
- R1: Every lookup is answered through registers. `rsp_valid` is high exactly in the cycle after a cycle with `req_valid` high, and low after a cycle with `req_valid` low.
- R2: After reset, every window is disabled and every segment-table entry holds group 0, so any lookup misses.
- R3: A window claims an address when the window is enabled and the address equals the base in every bit at or above the window's size exponent. Base bits below the size exponent are ignored, and the first address past the window is not claimed.
- R4: A remapping-window hit returns a bus address made of the remap value in the bits at or above the size exponent and the CPU address below it.
- R5: A remapping-window hit returns the table entry selected by address bits [size-1 : size-8] as its group. Both segment 0 and segment 255 are reachable.
- R6: A pass-through window hit returns the CPU address unchanged as the bus address.
- R7: An unsegmented pass-through window returns its programmed group for every address it claims.
- R8: A segmented pass-through window returns address bits [size-1 : size-8] as the group.
- R9: When windows overlap, the pass-through window with the lowest index wins, and any pass-through window wins over the remapping window. `rsp_win` gives the winner: 0-15 for pass-through windows and 16 for the remapping window.
- R10: A lookup that no enabled window claims returns `rsp_hit`=0, with `rsp_win`, `rsp_grp` and `rsp_pci_addr` all zero.
- R11: On `cfg_we` the write is selected by `cfg_kind`: 0 loads the remapping window, 1 loads segment-table entry `cfg_idx`, 2 loads pass-through window `cfg_idx`, and 3 loads the remap value. A kind-2 write with `cfg_idx` of 16 or more changes nothing.
- R12: The `cfg_data` fields are: base or remap value [47:0], size exponent [53:48], group [61:54], segmented flag [62] and enable [63]. Clearing the enable bit removes a window from the decode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_kind | input | 2 | Write target kind (see R11) |
| cfg_idx | input | 8 | Window number or segment-table index |
| cfg_data | input | 64 | Packed write fields (see R12) |
| req_valid | input | 1 | Lookup request valid |
| req_addr | input | 48 | CPU address to decode |
| rsp_valid | output | 1 | Response valid, one clock after the request |
| rsp_hit | output | 1 | Some window claimed the address |
| rsp_win | output | 5 | Winning window: 0-15 pass-through, 16 remapping |
| rsp_grp | output | 8 | Isolation group of the access |
| rsp_pci_addr | output | 48 | Bus address to issue |

## Verification
A configuration write is presented for one clock and takes effect at that clock's rising edge. A lookup is presented on the next falling edge, captured by the output registers at the following rising edge, and is therefore due exactly one clock after it was presented. The bench drives every request on a falling edge and reads all four response fields, plus `rsp_valid`, on the very next falling edge. This is half a cycle after the capturing edge and before any later request can disturb them. An idle cycle is read the same way, so a response that comes one cycle late or lingers one cycle too long is caught.

// File: rtl/mwd_pkg.sv
package mwd_pkg;
  localparam int ADDR_W = 48;
  localparam int SZ_W   = 6;
  localparam int SEG_W  = 8;
  localparam int GRP_W  = 8;
  localparam int DATA_W = 64;
  localparam int IDX_W  = 8;
  localparam int N_M64  = 16;
  localparam int WIN_W  = $clog2(N_M64 + 1);
  localparam int N_SEG  = 1 << SEG_W;

  localparam logic [1:0] KIND_M32_CFG   = 2'd0;
  localparam logic [1:0] KIND_M32_SEG   = 2'd1;
  localparam logic [1:0] KIND_M64_CFG   = 2'd2;
  localparam logic [1:0] KIND_M32_REMAP = 2'd3;

  // field positions inside a configuration word
  localparam int F_LG_LO  = ADDR_W;
  localparam int F_GRP_LO = F_LG_LO + SZ_W;
  localparam int F_SEG    = F_GRP_LO + GRP_W;
  localparam int F_EN     = F_SEG + 1;

  // ones at and above the size exponent
  function automatic logic [ADDR_W-1:0] upper_mask(input logic [SZ_W-1:0] lg);
    return ~((ADDR_W'(1) << lg) - ADDR_W'(1));
  endfunction

  // the SEG_W address bits just below the size exponent
  function automatic logic [SEG_W-1:0] seg_index(input logic [ADDR_W-1:0] a,
                                                 input logic [SZ_W-1:0] lg);
    return SEG_W'(a >> (lg - SZ_W'(SEG_W)));
  endfunction
endpackage

// File: rtl/mwd_m64_window.sv
module mwd_m64_window
  import mwd_pkg::*;
#(
  parameter int IDX = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [ADDR_W-1:0] wr_base,
  input  logic [SZ_W-1:0]   wr_lg,
  input  logic [GRP_W-1:0]  wr_grp,
  input  logic              wr_seg,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              hit,
  output logic [GRP_W-1:0]  grp
);
  logic              en_q, en_d, seg_q, seg_d;
  logic [ADDR_W-1:0] base_q, base_d;
  logic [SZ_W-1:0]   lg_q, lg_d;
  logic [GRP_W-1:0]  grp_q, grp_d;
  logic              sel;

  assign sel = ld && (wr_idx == IDX_W'(IDX));

  always_comb begin
    en_d   = en_q;
    seg_d  = seg_q;
    base_d = base_q;
    lg_d   = lg_q;
    grp_d  = grp_q;
    if (sel) begin
      en_d   = wr_en;
      seg_d  = wr_seg;
      base_d = wr_base;
      lg_d   = wr_lg;
      grp_d  = wr_grp;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      seg_q  <= 1'b0;
      base_q <= '0;
      lg_q   <= '0;
      grp_q  <= '0;
    end else begin
      en_q   <= en_d;
      seg_q  <= seg_d;
      base_q <= base_d;
      lg_q   <= lg_d;
      grp_q  <= grp_d;
    end
  end

  assign hit = en_q && (((lk_addr ^ base_q) & upper_mask(lg_q)) == '0);
  assign grp = seg_q ? seg_index(lk_addr, lg_q) : grp_q;
endmodule

// File: rtl/mwd_m32_window.sv
module mwd_m32_window
  import mwd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_cfg,
  input  logic              ld_seg,
  input  logic              ld_remap,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [ADDR_W-1:0] wr_base,
  input  logic [SZ_W-1:0]   wr_lg,
  input  logic [GRP_W-1:0]  wr_grp,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              hit,
  output logic [GRP_W-1:0]  grp,
  output logic [ADDR_W-1:0] pci_addr
);
  logic              en_q, en_d;
  logic [ADDR_W-1:0] base_q, base_d, remap_q, remap_d, hi;
  logic [SZ_W-1:0]   lg_q, lg_d;
  logic [GRP_W-1:0]  tbl_q [N_SEG];

  always_comb begin
    en_d    = en_q;
    base_d  = base_q;
    lg_d    = lg_q;
    remap_d = remap_q;
    if (ld_cfg) begin
      en_d   = wr_en;
      base_d = wr_base;
      lg_d   = wr_lg;
    end
    if (ld_remap) remap_d = wr_base;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      base_q  <= '0;
      lg_q    <= '0;
      remap_q <= '0;
    end else begin
      en_q    <= en_d;
      base_q  <= base_d;
      lg_q    <= lg_d;
      remap_q <= remap_d;
    end
  end

  // segment-to-group table, one clock enable per entry
  for (genvar s = 0; s < N_SEG; s++) begin : g_tbl
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  tbl_q[s] <= '0;
      else if (ld_seg && wr_idx == IDX_W'(s))      tbl_q[s] <= wr_grp;
    end
  end

  assign hi       = upper_mask(lg_q);
  assign hit      = en_q && (((lk_addr ^ base_q) & hi) == '0);
  assign grp      = tbl_q[seg_index(lk_addr, lg_q)];
  assign pci_addr = (remap_q & hi) | (lk_addr & ~hi);
endmodule

// File: rtl/mmio_win_decoder.sv
module mmio_win_decoder
  import mwd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_kind,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [DATA_W-1:0] cfg_data,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [WIN_W-1:0]  rsp_win,
  output logic [GRP_W-1:0]  rsp_grp,
  output logic [ADDR_W-1:0] rsp_pci_addr
);
  logic [ADDR_W-1:0] f_base;
  logic [SZ_W-1:0]   f_lg;
  logic [GRP_W-1:0]  f_grp;
  logic              f_seg, f_en;

  assign f_base = cfg_data[ADDR_W-1:0];
  assign f_lg   = cfg_data[F_LG_LO +: SZ_W];
  assign f_grp  = cfg_data[F_GRP_LO +: GRP_W];
  assign f_seg  = cfg_data[F_SEG];
  assign f_en   = cfg_data[F_EN];

  logic [N_M64-1:0] h64;
  logic [GRP_W-1:0] g64 [N_M64];

  for (genvar w = 0; w < N_M64; w++) begin : g_m64
    mwd_m64_window #(.IDX(w)) i_win (
      .clk(clk), .rst_n(rst_n),
      .ld(cfg_we && cfg_kind == KIND_M64_CFG),
      .wr_idx(cfg_idx), .wr_base(f_base), .wr_lg(f_lg), .wr_grp(f_grp),
      .wr_seg(f_seg), .wr_en(f_en), .lk_addr(req_addr),
      .hit(h64[w]), .grp(g64[w])
    );
  end

  logic              h32;
  logic [GRP_W-1:0]  g32;
  logic [ADDR_W-1:0] p32;

  mwd_m32_window i_m32 (
    .clk(clk), .rst_n(rst_n),
    .ld_cfg(cfg_we && cfg_kind == KIND_M32_CFG),
    .ld_seg(cfg_we && cfg_kind == KIND_M32_SEG),
    .ld_remap(cfg_we && cfg_kind == KIND_M32_REMAP),
    .wr_idx(cfg_idx), .wr_base(f_base), .wr_lg(f_lg), .wr_grp(f_grp),
    .wr_en(f_en), .lk_addr(req_addr),
    .hit(h32), .grp(g32), .pci_addr(p32)
  );

  // fixed priority: lowest pass-through index, then the remapping window
  logic              sel_hit;
  logic [WIN_W-1:0]  sel_win;
  logic [GRP_W-1:0]  sel_grp;
  logic [ADDR_W-1:0] sel_pci;

  always_comb begin
    sel_hit = h32;
    sel_win = WIN_W'(N_M64);
    sel_grp = g32;
    sel_pci = p32;
    for (int i = N_M64 - 1; i >= 0; i--) begin
      if (h64[i]) begin
        sel_hit = 1'b1;
        sel_win = WIN_W'(i);
        sel_grp = g64[i];
        sel_pci = req_addr;
      end
    end
    if (!(sel_hit && req_valid)) begin
      sel_hit = 1'b0;
      sel_win = '0;
      sel_grp = '0;
      sel_pci = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid    <= 1'b0;
      rsp_hit      <= 1'b0;
      rsp_win      <= '0;
      rsp_grp      <= '0;
      rsp_pci_addr <= '0;
    end else begin
      rsp_valid    <= req_valid;
      rsp_hit      <= sel_hit;
      rsp_win      <= sel_win;
      rsp_grp      <= sel_grp;
      rsp_pci_addr <= sel_pci;
    end
  end
endmodule

// File: rtl/mwd_checker.sv
module mwd_checker
  import mwd_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [ADDR_W-1:0] req_addr,
  input logic              rsp_valid,
  input logic              rsp_hit,
  input logic [WIN_W-1:0]  rsp_win,
  input logic [GRP_W-1:0]  rsp_grp,
  input logic [ADDR_W-1:0] rsp_pci_addr
);
  p_rsp_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  p_rsp_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid && !rsp_hit);

  p_miss_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_hit |-> rsp_win == '0 && rsp_grp == '0 && rsp_pci_addr == '0);

  p_win_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> rsp_win <= WIN_W'(N_M64));

  p_passthru_r6: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (rsp_hit && rsp_win < WIN_W'(N_M64)) -> rsp_pci_addr == $past(req_addr));
endmodule

bind mmio_win_decoder mwd_checker i_mwd_checker (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
  .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_win(rsp_win),
  .rsp_grp(rsp_grp), .rsp_pci_addr(rsp_pci_addr)
);

// File: tb/test_mmio_win_decoder.sv
module test_mmio_win_decoder;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [1:0]  cfg_kind;
  logic [7:0]  cfg_idx;
  logic [63:0] cfg_data;
  logic        req_valid;
  logic [47:0] req_addr;
  logic        rsp_valid, rsp_hit;
  logic [4:0]  rsp_win;
  logic [7:0]  rsp_grp;
  logic [47:0] rsp_pci_addr;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  mmio_win_decoder i_mmio_win_decoder (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_kind(cfg_kind),
    .cfg_idx(cfg_idx), .cfg_data(cfg_data), .req_valid(req_valid),
    .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .rsp_win(rsp_win), .rsp_grp(rsp_grp), .rsp_pci_addr(rsp_pci_addr)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // R12 field layout: en[63] seg[62] grp[61:54] lg[53:48] base[47:0]
  function automatic logic [63:0] word(input logic en, input logic seg,
      input logic [7:0] grp, input logic [5:0] lg, input logic [47:0] base);
    return {en, seg, grp, lg, base};
  endfunction

  task automatic wr(input logic [1:0] kind, input logic [7:0] idx, input logic [63:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_kind = kind; cfg_idx = idx; cfg_data = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic look(input string tag, input logic [47:0] a, input logic ehit,
      input logic [4:0] ewin, input logic [7:0] egrp, input logic [47:0] epci);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    chk({tag, " R1 valid"}, 64'(rsp_valid), 64'd1);
    chk({tag, " hit"}, 64'(rsp_hit), 64'(ehit));
    chk({tag, " win"}, 64'(rsp_win), 64'(ewin));
    chk({tag, " grp"}, 64'(rsp_grp), 64'(egrp));
    chk({tag, " pci"}, 64'(rsp_pci_addr), 64'(epci));
  endtask

  task automatic t_reset_state;
    chk("R1 reset valid", 64'(rsp_valid), 64'd0);
    look("R2 R10 reset miss", 48'h3F_8000_0000, 0, 0, 0, 0);
    look("R2 R10 reset miss hi", 48'hFF_FFFF_FFFF, 0, 0, 0, 0);
  endtask

  task automatic t_m32_window;
    wr(2'd3, 0, word(0, 0, 0, 0, 48'h0000_8000_0000));
    wr(2'd0, 0, word(1, 0, 0, 6'd31, 48'h3F_8000_0000));
    wr(2'd1, 5, word(0, 0, 8'h42, 0, 0));
    wr(2'd1, 255, word(0, 0, 8'hC3, 0, 0));
    look("R4 R5 R11 seg5", 48'h3F_8280_0123, 1, 16, 8'h42, 48'h0000_8280_0123);
    look("R2 R5 seg0 default", 48'h3F_8000_0010, 1, 16, 8'h00, 48'h0000_8000_0010);
    look("R5 seg255", 48'h3F_FFFF_FFFF, 1, 16, 8'hC3, 48'h0000_FFFF_FFFF);
    look("R3 below m32", 48'h3F_7FFF_FFFF, 0, 0, 0, 0);
    look("R3 past m32", 48'h40_0000_0000, 0, 0, 0, 0);
  endtask

  task automatic t_remap;
    wr(2'd3, 0, word(0, 0, 0, 0, 48'h0012_4000_0000));
    look("R4 remap upper only", 48'h3F_8280_0123, 1, 16, 8'h42, 48'h0012_0280_0123);
  endtask

  task automatic t_m64_unseg;
    wr(2'd2, 3, word(1, 0, 8'h77, 6'd30, 48'h40_0000_0000));
    look("R6 R7 win3", 48'h40_1234_5678, 1, 3, 8'h77, 48'h40_1234_5678);
    look("R3 R7 win3 last", 48'h40_3FFF_FFFF, 1, 3, 8'h77, 48'h40_3FFF_FFFF);
    look("R3 win3 past end", 48'h40_4000_0000, 0, 0, 0, 0);
    wr(2'd2, 4, word(1, 0, 8'h44, 6'd28, 48'h50_0000_1234));
    look("R3 base low bits ignored", 48'h50_0000_0000, 1, 4, 8'h44, 48'h50_0000_0000);
  endtask

  task automatic t_m64_seg;
    wr(2'd2, 7, word(1, 1, 8'h3C, 6'd36, 48'h80_0000_0000));
    look("R8 seg A5", 48'h8A_5000_0000, 1, 7, 8'hA5, 48'h8A_5000_0000);
    look("R8 seg FF", 48'h8F_FFFF_FFFF, 1, 7, 8'hFF, 48'h8F_FFFF_FFFF);
    look("R8 seg 00", 48'h80_0000_0004, 1, 7, 8'h00, 48'h80_0000_0004);
  endtask

  task automatic t_priority;
    wr(2'd2, 2, word(1, 0, 8'h11, 6'd28, 48'h40_0000_0000));
    look("R9 win2 over win3", 48'h40_0123_4567, 1, 2, 8'h11, 48'h40_0123_4567);
    look("R9 win3 outside win2", 48'h40_1234_5678, 1, 3, 8'h77, 48'h40_1234_5678);
    wr(2'd2, 9, word(1, 0, 8'h99, 6'd28, 48'h3F_8000_0000));
    look("R9 R6 m64 over m32", 48'h3F_8280_0123, 1, 9, 8'h99, 48'h3F_8280_0123);
    wr(2'd2, 9, word(0, 0, 8'h99, 6'd28, 48'h3F_8000_0000));
    look("R12 disabled win9", 48'h3F_8280_0123, 1, 16, 8'h42, 48'h0012_0280_0123);
  endtask

  task automatic t_ignored_write;
    wr(2'd2, 8'd20, word(1, 0, 8'h55, 6'd28, 48'h10_0000_0000));
    look("R11 idx20 ignored", 48'h10_0000_0000, 0, 0, 0, 0);
  endtask

  task automatic t_idle;
    @(negedge clk);
    req_valid = 1'b0; req_addr = 48'h40_1234_5678;
    @(negedge clk);
    chk("R1 idle valid", 64'(rsp_valid), 64'd0);
    chk("R1 idle hit", 64'(rsp_hit), 64'd0);
  endtask

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_kind = '0; cfg_idx = '0; cfg_data = '0;
    req_valid = 1'b0; req_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset_state();
    t_m32_window();
    t_remap();
    t_m64_unseg();
    t_m64_seg();
    t_priority();
    t_ignored_write();
    t_idle();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule